// File: doc/BRIEF.md
# Serial Radio Data Bit Buffer with Two Readout Protocols

This block sits after a radio data demodulator. Each decoded data bit arrives with a one-cycle valid strobe. The block keeps the bits in a small first-in first-out bit store and hands them to a host over a two-wire serial link, a clock and a data line. Two pins select the operating mode.

- **MASTER**: the block drives the link clock itself from a programmable divider. A status line carries an active-low identification flag.
- **SLAVE**: the host supplies the link clock. The status line carries an active-low data-waiting flag.
- **STANDBY**: everything freezes and the stored bits are kept.
- **TEST**: reserved. It behaves like STANDBY.

The mode comes straight from the pins, with no transition delay: `{sel_test,sel_mode}` = 00 gives MASTER, 01 gives SLAVE, 10 gives STANDBY and 11 gives TEST. Changing mode requires no reset.

The link-clock generator is a two-state machine.
- **CK_LO to CK_HI (rise)**: taken once the clock has been low for `HALF_PERIOD` system cycles.
- **CK_HI to CK_LO (fall)**: taken after `HALF_PERIOD` high cycles. On this transition the next stored bit is presented on `data_out`.

The status pin is open-drain. It is modelled as `stat_oe`: a 1 pulls the pin low, and a 0 releases it. The bidirectional link clock pin is split into `rclk_in`, `rclk_out` and the drive enable `rclk_oe`.

Top module: `rds_bitbuf`

## Requirements
- R1: The mode decode of `{sel_test,sel_mode}` is 00 MASTER, 01 SLAVE, 10 STANDBY and 11 TEST. `rclk_oe` is 1 only in MASTER.
- R2: The store holds `DEPTH` bits (default 128). Bits leave on `data_out` in arrival order, oldest first.
- R3: A strobed bit arriving while the store is full, with no read in the same cycle, discards the oldest bit and sets the sticky flag `ovf`. A full store that is read and written in the same cycle does not set `ovf`.
- R4: In MASTER, `rclk_out` is low after `clr` and toggles every `HALF_PERIOD` system cycles.
- R5: In MASTER, the clock edge that takes `rclk_out` from high to low also loads the oldest stored bit into `data_out`. When the store is empty, `data_out` holds its value.
- R6: In MASTER, `stat_oe` equals an identification flag. The flag is set by `id_det` while running and cleared by `clr`.
- R7: In SLAVE, `rclk_in` passes through two synchronizing flops. A detected falling edge loads the oldest stored bit into `data_out` on the third rising system clock edge after the first edge that samples `rclk_in` low.
- R8: In SLAVE, `stat_oe` is 1 exactly while the store is non-empty.
- R9: `clr` asserted in SLAVE empties the store and clears `ovf`. In MASTER or STANDBY, `clr` keeps the stored bits.
- R10: In STANDBY and TEST, strobed bits are dropped, no bit is read, the link clock does not advance, `data_out` holds, and `stat_oe` and `rclk_oe` are 0. Returning to a running mode resumes with the contents intact.
- R11: `clr` in any mode clears `data_out` to 0, returns the link clock to CK_LO with its divider at zero, resets the input synchronizer and clears the identification flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Active-high synchronous clear |
| sel_test | input | 1 | Upper mode select bit |
| sel_mode | input | 1 | Lower mode select bit |
| bit_vld | input | 1 | Strobe for `bit_in` |
| bit_in | input | 1 | Decoded data bit |
| id_det | input | 1 | Identification detected pulse |
| rclk_in | input | 1 | Host-driven link clock (SLAVE) |
| rclk_out | output | 1 | Block-driven link clock level (MASTER) |
| rclk_oe | output | 1 | Drive enable for the link clock pin |
| data_out | output | 1 | Serial data output |
| stat_oe | output | 1 | Open-drain status pull-down enable |
| ovf | output | 1 | Sticky overflow flag |

## Verification
A corrupted read or write pointer shows on `data_out` at the next falling link clock edge: a bit comes out of order or out of the wrong position in the stream. A count that is off by one shows on `stat_oe` in SLAVE. The status flag either releases while data is still waiting or stays asserted after the last pop, and the miscompare appears in the very cycle after the last read. A wrong divider or clock-state value shows as a shifted `rclk_out` edge within one half period. A wrong mode decode shows on `rclk_oe` in the same cycle the pins change.

// File: rtl/rds_bitbuf_pkg.sv
package rds_bitbuf_pkg;

    typedef enum logic [1:0] {
        OM_MASTER = 2'b00,
        OM_SLAVE  = 2'b01,
        OM_STBY   = 2'b10,
        OM_TEST   = 2'b11
    } op_mode_e;

    typedef enum logic {
        CK_LO = 1'b0,
        CK_HI = 1'b1
    } ck_state_e;

    function automatic op_mode_e decode_mode(input logic t, input logic m);
        op_mode_e r;
        unique case ({t, m})
            2'b00:   r = OM_MASTER;
            2'b01:   r = OM_SLAVE;
            2'b10:   r = OM_STBY;
            default: r = OM_TEST;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rds_bit_fifo.sv
module rds_bit_fifo #(
    parameter int DEPTH = 128
) (
    input  logic clk,
    input  logic clear_i,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic rd_en,
    output logic rd_bit,
    output logic empty_o,
    output logic ovf_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [DEPTH-1:0] mem;
    logic [AW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             ovf_q;
    logic             full, do_rd, drop;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (cnt_q == CW'(DEPTH));
    assign do_rd = rd_en && (cnt_q != '0);
    assign drop  = wr_en && full && !do_rd;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp_q] <= wr_bit;
    end

    always_ff @(posedge clk) begin
        if (clear_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_en)         wp_q  <= adv(wp_q);
            if (do_rd || drop) rp_q  <= adv(rp_q);
            if (drop)          ovf_q <= 1'b1;
            unique case ({wr_en && !drop, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rd_bit  = mem[rp_q];
    assign empty_o = (cnt_q == '0);
    assign ovf_o   = ovf_q;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (clear_i)
        cnt_q <= CW'(DEPTH));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (clear_i)
        ovf_q |=> ovf_q);

endmodule

// File: rtl/rds_mclk_gen.sv
module rds_mclk_gen
    import rds_bitbuf_pkg::*;
#(
    parameter int HALF_PERIOD = 1824
) (
    input  logic clk,
    input  logic clr_i,
    input  logic run_i,
    output logic level_o,
    output logic fall_o
);
    localparam int CNTW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(HALF_PERIOD - 1);

    ck_state_e       state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic            wrap;

    assign wrap = run_i && (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_LO: if (wrap) state_d = CK_HI;
            CK_HI: if (wrap) state_d = CK_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr_i) begin
            state_q <= CK_LO;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (wrap)       cnt_q <= '0;
            else if (run_i) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        level_o = (state_q == CK_HI);
        fall_o  = (state_q == CK_HI) && (state_d == CK_LO);
    end

    p_phase_hold_r4: assert property (@(posedge clk) disable iff (clr_i)
        (!run_i || cnt_q != LAST) |=> $stable(level_o));

endmodule

// File: rtl/rds_edge_sync.sv
module rds_edge_sync (
    input  logic clk,
    input  logic clr_i,
    input  logic run_i,
    input  logic line_i,
    output logic fall_o
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (clr_i) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else if (run_i) begin
            s1_q <= line_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign fall_o = run_i && s3_q && !s2_q;

    p_fall_gap_r7: assert property (@(posedge clk) disable iff (clr_i)
        fall_o |=> !fall_o);

endmodule

// File: rtl/rds_bitbuf.sv
module rds_bitbuf
    import rds_bitbuf_pkg::*;
#(
    parameter int DEPTH       = 128,
    parameter int HALF_PERIOD = 1824
) (
    input  logic clk,
    input  logic clr,
    input  logic sel_test,
    input  logic sel_mode,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic id_det,
    input  logic rclk_in,
    output logic rclk_out,
    output logic rclk_oe,
    output logic data_out,
    output logic stat_oe,
    output logic ovf
);
    op_mode_e mode;
    logic     run, is_master, is_slave;
    logic     m_fall, s_fall, pop;
    logic     head_bit, empty;
    logic     id_q, dout_q;

    assign mode      = decode_mode(sel_test, sel_mode);
    assign is_master = (mode == OM_MASTER);
    assign is_slave  = (mode == OM_SLAVE);
    assign run       = is_master || is_slave;

    rds_bit_fifo #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .clear_i (clr && is_slave),
        .wr_en   (bit_vld && run && !clr),
        .wr_bit  (bit_in),
        .rd_en   (pop && !clr),
        .rd_bit  (head_bit),
        .empty_o (empty),
        .ovf_o   (ovf)
    );

    rds_mclk_gen #(.HALF_PERIOD(HALF_PERIOD)) u_mclk (
        .clk     (clk),
        .clr_i   (clr),
        .run_i   (is_master),
        .level_o (rclk_out),
        .fall_o  (m_fall)
    );

    rds_edge_sync u_sync (
        .clk    (clk),
        .clr_i  (clr),
        .run_i  (is_slave),
        .line_i (rclk_in),
        .fall_o (s_fall)
    );

    always_comb begin
        pop     = 1'b0;
        stat_oe = 1'b0;
        rclk_oe = 1'b0;
        unique case (mode)
            OM_MASTER: begin
                pop     = m_fall;
                stat_oe = id_q;
                rclk_oe = 1'b1;
            end
            OM_SLAVE: begin
                pop     = s_fall;
                stat_oe = !empty;
            end
            OM_STBY, OM_TEST: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            id_q   <= 1'b0;
            dout_q <= 1'b0;
        end else if (run) begin
            if (id_det)         id_q   <= 1'b1;
            if (pop && !empty)  dout_q <= head_bit;
        end
    end

    assign data_out = dout_q;

    p_stby_hold_r10: assert property (@(posedge clk) disable iff (clr)
        !run |=> $stable(data_out));

endmodule

// File: tb/rds_bitbuf_bench.sv
module rds_bitbuf_bench;
    localparam int DEPTH = 8;
    localparam int HALF  = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic clr = 1'b1, sel_test = 1'b0, sel_mode = 1'b1;
    logic bit_vld = 1'b0, bit_in = 1'b0, id_det = 1'b0, rclk_in = 1'b0;
    logic rclk_out, rclk_oe, data_out, stat_oe, ovf;

    rds_bitbuf #(.DEPTH(DEPTH), .HALF_PERIOD(HALF)) u_rds_bitbuf (
        .clk(clk), .clr(clr), .sel_test(sel_test), .sel_mode(sel_mode),
        .bit_vld(bit_vld), .bit_in(bit_in), .id_det(id_det), .rclk_in(rclk_in),
        .rclk_out(rclk_out), .rclk_oe(rclk_oe), .data_out(data_out),
        .stat_oe(stat_oe), .ovf(ovf)
    );

    int vecs = 0, bad = 0;
    bit q[$];
    bit ovf_m = 0, id_m = 0, dout_m = 0, ckhi_m = 0;
    int cnt_m = 0;
    bit h1 = 0, h2 = 0, h3 = 0;

    // Behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        int  md;
        bit  fall;
        md   = {sel_test, sel_mode};
        fall = 0;
        if (clr) begin
            id_m = 0; dout_m = 0; ckhi_m = 0; cnt_m = 0;
            h1 = 0; h2 = 0; h3 = 0;
            if (md == 1) begin q.delete(); ovf_m = 0; end
        end else if (md <= 1) begin
            if (md == 0) begin
                fall = ckhi_m && (cnt_m == HALF - 1);
                if (cnt_m == HALF - 1) begin cnt_m = 0; ckhi_m = !ckhi_m; end
                else cnt_m++;
            end else begin
                fall = h3 && !h2;
                h3 = h2; h2 = h1; h1 = rclk_in;
            end
            if (fall && q.size() > 0) dout_m = q.pop_front();
            if (bit_vld) begin
                if (q.size() == DEPTH) begin void'(q.pop_front()); ovf_m = 1; end
                q.push_back(bit_in);
            end
            if (id_det) id_m = 1;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the rising edge
    always @(negedge clk) begin
        int  md;
        bit  st;
        md = {sel_test, sel_mode};
        st = (md == 0) ? id_m : (md == 1) ? (q.size() > 0) : 1'b0;
        chk(data_out, dout_m, "R2 R5 R7 data_out");
        chk(stat_oe, st, "R6 R8 R10 stat_oe");
        chk(rclk_oe, md == 0, "R1 rclk_oe");
        chk(rclk_out, ckhi_m, "R4 rclk_out");
        chk(ovf, ovf_m, "R3 R9 ovf");
    end

    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic push(input bit b);
        bit_vld = 1; bit_in = b; step(1); bit_vld = 0;
    endtask

    task automatic pulse();
        rclk_in = 1; step(3); rclk_in = 0; step(4);
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        step(3);
        clr = 0; step(1);
        chk(data_out, 1'b0, "R11 reset data");
        chk(stat_oe, 1'b0, "R8 reset empty");
        chk(ovf, 1'b0, "R3 reset ovf");
        chk(rclk_oe, 1'b0, "R1 slave no drive");

        // SLAVE: ordered readout
        push(1); push(0); push(1); push(1); push(0);
        step(1);
        chk(stat_oe, 1'b1, "R8 ready");
        pulse(); chk(data_out, 1'b1, "R7 first bit");
        pulse(); chk(data_out, 1'b0, "R2 second bit");
        pulse();

        // Overflow past DEPTH
        for (int i = 0; i < 10; i++) push(i[0]);
        step(1);
        chk(ovf, 1'b1, "R3 overflow");

        // Pop while writing
        rclk_in = 1; step(3); rclk_in = 0; push(1); push(0); step(4);
        for (int i = 0; i < 12; i++) pulse();
        chk(stat_oe, 1'b0, "R8 drained");

        // Clear in SLAVE
        push(1); push(1); step(1);
        clr = 1; step(1); clr = 0; step(1);
        chk(stat_oe, 1'b0, "R9 slave clear empties");
        chk(ovf, 1'b0, "R9 slave clear ovf");

        // MASTER
        push(1); push(0); push(0); push(1);
        sel_mode = 0; step(1);
        chk(rclk_oe, 1'b1, "R1 master drives");
        id_det = 1; step(1); id_det = 0; step(1);
        chk(stat_oe, 1'b1, "R6 id flag");
        step(20);
        push(1); push(1); push(0);
        step(4);
        clr = 1; step(1); clr = 0; step(1);
        chk(stat_oe, 1'b0, "R11 id cleared");
        chk(rclk_out, 1'b0, "R11 clock low");
        step(30);

        // STANDBY and TEST
        push(0); push(1); push(1);
        sel_test = 1; step(2);
        chk(stat_oe, 1'b0, "R10 status released");
        chk(rclk_oe, 1'b0, "R10 clock released");
        push(1); push(0); step(8);
        sel_mode = 1; push(1); step(6);
        clr = 1; step(1); clr = 0; step(2);
        sel_test = 0; step(2);
        chk(stat_oe, 1'b1, "R10 contents kept");
        for (int i = 0; i < 6; i++) pulse();
        chk(stat_oe, 1'b0, "R8 final drain");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule